// File: doc/BRIEF.md
# Segmented Page Address Converter

This block turns a flat byte address into the page/offset address that a serial data-flash device expects when its pages may hold a number of bytes that is not a power of two. A controller sets a linear byte address, the transfer length, a nominal page-size selection and the device's power-of-two status bit, then pulses `start`. The block divides the address by the real page size with a sequential restoring divider, one quotient bit per clock. It then places the page index above an offset field. The width of that field is the number of bits needed to hold the page size minus one.

The result comes out as a 24-bit address split into three bytes, most significant byte first, with a one-cycle `done` pulse. When the status bit reports power-of-two pages, the real page size equals the nominal one. When the bit is clear, the real page size is 33/32 of the nominal value, so the offset field no longer fills the page range and a real division is needed. A request that runs past the end of the device, or that selects an unsupported page size, is flagged with `err`, and its address bytes are zero.

Top module: `dfpa_seg_addr`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and all three address bytes are 0x00.
- R2: `size_sel` 0, 1 and 2 select nominal pages of 256, 512 and 1024 bytes. With `pow2_flag` = 0 the real page size is the nominal size plus one thirty-second of it (264, 528, 1056). With `pow2_flag` = 1 it is the nominal size.
- R3: The offset field width is the smallest bit count that can hold (page size − 1): 8 for 256, 9 for 264 and 512, 10 for 528 and 1024, 11 for 1056.
- R4: On success, the output address equals (address / page size) shifted left by the offset width, OR (address mod page size). This includes the case of a remainder of page size − 1 and the case of an exact page multiple.
- R5: With `pow2_flag` = 1 and no error, the output address equals the input address.
- R6: `addr_hi` carries bits 23:16 of the result, `addr_mid` bits 15:8 and `addr_lo` bits 7:0.
- R7: When address + length is greater than `PAGE_COUNT` × real page size, the result has `err` = 1 and all address bytes 0. Address + length equal to that total is accepted.
- R8: `busy` is 1 from the clock after an accepted `start`. `done` rises exactly 25 clock edges after the edge that accepted `start`, lasts one cycle, and `busy` falls with it.
- R9: A `start` while `busy` is 1 is ignored, and the result belongs to the first request. The address bytes and `err` change only with `done` and hold between results.
- R10: `size_sel` = 3 is an unsupported page size. It gives `err` = 1 and zero address bytes, with the same latency as a normal request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| lin_addr | input | 24 | Linear byte address |
| xfer_len | input | 24 | Transfer length in bytes, used for the range check |
| size_sel | input | 2 | Nominal page size: 0=256, 1=512, 2=1024, 3=unsupported |
| pow2_flag | input | 1 | Device status bit: 1 = power-of-two pages |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request rejected (range or page size) |
| addr_hi | output | 8 | Result bits 23:16 |
| addr_mid | output | 8 | Result bits 15:8 |
| addr_lo | output | 8 | Result bits 7:0 |

## Verification
A divider iteration counter that is off by one makes `done` come out one edge early or late, and it corrupts the lowest quotient bit. Both show up on the first request. A wrong restoring decision, or a divisor that is latched badly, gives wrong page and offset fields on the first non-power-of-two request, while power-of-two requests still pass through unchanged. A wrong offset width shifts the page index by one bit, which is visible in `addr_mid` for any page index above zero. Range and size errors are visible at the `done` of the same request, and a restart taken while busy changes the bytes of the result being computed.

// File: rtl/dfpa_pkg.sv
package dfpa_pkg;

  localparam int PSZ_W = 11;  // widest real page size (1056) fits in 11 bits
  localparam int OFB_W = 4;   // offset-width value, at most 11

  typedef enum logic [1:0] {
    PG_NOM_256  = 2'd0,
    PG_NOM_512  = 2'd1,
    PG_NOM_1024 = 2'd2,
    PG_NOM_BAD  = 2'd3
  } pg_sel_e;

  // Real page size from the nominal selection and the power-of-two status bit.
  function automatic logic [PSZ_W-1:0] page_size_f(input pg_sel_e sel, input logic pow2);
    logic [PSZ_W-1:0] nom;
    case (sel)
      PG_NOM_256:  nom = 11'd256;
      PG_NOM_512:  nom = 11'd512;
      PG_NOM_1024: nom = 11'd1024;
      default:     nom = 11'd256;
    endcase
    return pow2 ? nom : (nom + (nom >> 5));
  endfunction

  // Smallest bit count that holds (size - 1).
  function automatic logic [OFB_W-1:0] offset_bits_f(input logic [PSZ_W-1:0] size);
    logic [PSZ_W-1:0] top;
    logic [OFB_W-1:0] n;
    top = size - 1'b1;
    n = '0;
    for (int i = 0; i < PSZ_W; i++) begin
      if (top[i]) n = OFB_W'(i + 1);
    end
    return n;
  endfunction

endpackage

// File: rtl/dfpa_page_cfg.sv
module dfpa_page_cfg
  import dfpa_pkg::*;
#(
  parameter int AW         = 24,
  parameter int PAGE_COUNT = 4096
) (
  input  logic [1:0]       sel_i,
  input  logic             pow2_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    len_i,
  output logic [PSZ_W-1:0] size_o,
  output logic [OFB_W-1:0] bits_o,
  output logic             sel_ok_o,
  output logic             fits_o
);
  localparam int TW = AW + 2;

  pg_sel_e       sel_e;
  logic [TW-1:0] total_w;
  logic [TW-1:0] end_w;

  always_comb begin
    sel_e    = pg_sel_e'(sel_i);
    size_o   = page_size_f(sel_e, pow2_i);
    bits_o   = offset_bits_f(size_o);
    sel_ok_o = (sel_e != PG_NOM_BAD);
    total_w  = TW'(PAGE_COUNT) * TW'(size_o);
    end_w    = TW'(base_i) + TW'(len_i);
    fits_o   = (end_w <= total_w);
  end
endmodule

// File: rtl/dfpa_div.sv
module dfpa_div #(
  parameter int DW = 24,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic [DW-1:0] quo_o,
  output logic [VW-1:0] rem_o,
  output logic          fin_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q;
  logic [VW-1:0] rem_q;
  logic [VW-1:0] dsr_q;
  logic [CW-1:0] cnt_q;
  logic          fin_q;

  logic [VW:0]   shifted_w;
  logic [VW+1:0] trial_w;
  logic          keep_w;

  always_comb begin
    shifted_w = {rem_q, quo_q[DW-1]};
    trial_w   = {1'b0, shifted_w} - {2'b00, dsr_q};
    keep_w    = ~trial_w[VW+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        quo_q <= dividend_i;
        rem_q <= '0;
        dsr_q <= divisor_i;
        cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        rem_q <= keep_w ? trial_w[VW-1:0] : shifted_w[VW-1:0];
        quo_q <= {quo_q[DW-2:0], keep_w};
        cnt_q <= cnt_q - 1'b1;
        fin_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/dfpa_pack.sv
module dfpa_pack #(
  parameter int AW = 24,
  parameter int SW = 11,
  parameter int BW = 4
) (
  input  logic [AW-1:0]          quo_i,
  input  logic [SW-1:0]          rem_i,
  input  logic [BW-1:0]          bits_i,
  output logic [AW-1:0]          word_o,
  output logic [AW/8-1:0][7:0]   bytes_o
);
  localparam int NB = AW / 8;

  always_comb begin
    word_o = (quo_i << bits_i) | {{(AW-SW){1'b0}}, rem_i};
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign bytes_o[g] = word_o[8*g +: 8];
  end
endmodule

// File: rtl/dfpa_seg_addr.sv
module dfpa_seg_addr
  import dfpa_pkg::*;
#(
  parameter int AW         = 24,
  parameter int PAGE_COUNT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] lin_addr,
  input  logic [AW-1:0] xfer_len,
  input  logic [1:0]    size_sel,
  input  logic          pow2_flag,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    addr_hi,
  output logic [7:0]    addr_mid,
  output logic [7:0]    addr_lo
);
  localparam int NB = AW / 8;

  logic             busy_q, done_q, rej_q, err_q;
  logic [OFB_W-1:0] bits_q;
  logic [AW-1:0]    out_q;

  logic             accept_w;
  logic             div_fin_w;
  logic [PSZ_W-1:0] cfg_size_w;
  logic [OFB_W-1:0] cfg_bits_w;
  logic             cfg_ok_w, cfg_fit_w;
  logic [AW-1:0]    quo_w;
  logic [PSZ_W-1:0] rem_w;
  logic [AW-1:0]    word_w;
  logic [NB-1:0][7:0] bytes_w;
  logic [NB-1:0][7:0] out_bytes_w;

  assign accept_w = start & ~busy_q;

  dfpa_page_cfg #(.AW(AW), .PAGE_COUNT(PAGE_COUNT)) u_cfg (
    .sel_i   (size_sel),
    .pow2_i  (pow2_flag),
    .base_i  (lin_addr),
    .len_i   (xfer_len),
    .size_o  (cfg_size_w),
    .bits_o  (cfg_bits_w),
    .sel_ok_o(cfg_ok_w),
    .fits_o  (cfg_fit_w)
  );

  dfpa_div #(.DW(AW), .VW(PSZ_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (accept_w),
    .dividend_i(lin_addr),
    .divisor_i (cfg_size_w),
    .quo_o     (quo_w),
    .rem_o     (rem_w),
    .fin_o     (div_fin_w)
  );

  dfpa_pack #(.AW(AW), .SW(PSZ_W), .BW(OFB_W)) u_pack (
    .quo_i  (quo_w),
    .rem_i  (rem_w),
    .bits_i (bits_q),
    .word_o (word_w),
    .bytes_o(bytes_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      err_q  <= 1'b0;
      bits_q <= '0;
      out_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        busy_q <= 1'b1;
        bits_q <= cfg_bits_w;
        rej_q  <= ~(cfg_ok_w & cfg_fit_w);
      end else if (busy_q && div_fin_w) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= rej_q;
        out_q  <= rej_q ? '0 : {bytes_w};
      end
    end
  end

  assign out_bytes_w = out_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign addr_hi  = out_bytes_w[2];
  assign addr_mid = out_bytes_w[1];
  assign addr_lo  = out_bytes_w[0];

  logic unused_w;
  assign unused_w = ^word_w;
endmodule

// File: rtl/dfpa_chk.sv
module dfpa_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lin_addr_sel_unused,
  input logic [AW-1:0] lin_addr,
  input logic [1:0]    size_sel,
  input logic          pow2_flag,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [7:0]    addr_hi,
  input logic [7:0]    addr_mid,
  input logic [7:0]    addr_lo,
  input logic          accept_w,
  input logic          div_fin_w
);
  localparam int LAT_SEEN = AW + 2;

  logic [AW-1:0] cap_addr_q;
  logic          cap_pow2_q;
  logic [1:0]    cap_sel_q;
  logic [7:0]    lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_pow2_q <= 1'b0;
      cap_sel_q  <= '0;
      lat_q      <= '0;
    end else begin
      if (accept_w) begin
        cap_addr_q <= lin_addr;
        cap_pow2_q <= pow2_flag;
        cap_sel_q  <= size_sel;
        lat_q      <= 8'd1;
      end else if (done) begin
        lat_q <= '0;
      end else if (lat_q != '0) begin
        lat_q <= lat_q + 1'b1;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat_q == 8'(LAT_SEEN)));

  // R8
  fin_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n) div_fin_w |=> done);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({addr_hi, addr_mid, addr_lo, err}));

  // R5
  pow2_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && cap_pow2_q) |-> ({addr_hi, addr_mid, addr_lo} == cap_addr_q));

  // R10
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_sel_q == 2'd3) |-> (err && {addr_hi, addr_mid, addr_lo} == '0));

  logic unused_w;
  assign unused_w = lin_addr_sel_unused;
endmodule

bind dfpa_seg_addr dfpa_chk #(.AW(AW)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .lin_addr_sel_unused(1'b0),
  .lin_addr           (lin_addr),
  .size_sel           (size_sel),
  .pow2_flag          (pow2_flag),
  .busy               (busy),
  .done               (done),
  .err                (err),
  .addr_hi            (addr_hi),
  .addr_mid           (addr_mid),
  .addr_lo            (addr_lo),
  .accept_w           (accept_w),
  .div_fin_w          (div_fin_w)
);

// File: tb/dfpa_seg_addr_test.sv
`timescale 1ns/1ps
module dfpa_seg_addr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] lin_addr = '0;
  logic [23:0] xfer_len = '0;
  logic [1:0]  size_sel = '0;
  logic        pow2_flag = 1'b1;
  logic        busy, done, err;
  logic [7:0]  addr_hi, addr_mid, addr_lo;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    logic [24:0] exp;
    string       req;
  } sb_t;
  sb_t sbq[$];

  always #2.5 clk = ~clk;

  dfpa_seg_addr uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lin_addr(lin_addr), .xfer_len(xfer_len),
    .size_sel(size_sel), .pow2_flag(pow2_flag), .busy(busy), .done(done), .err(err),
    .addr_hi(addr_hi), .addr_mid(addr_mid), .addr_lo(addr_lo)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Independent model: {err, address}
  function automatic logic [24:0] model(input int sel, input bit p2, input int a, input int n);
    int sz, b, tot;
    if (sel == 3) return {1'b1, 24'h0};
    sz = 256 * (1 << sel);
    if (!p2) sz = (sz / 32) * 33;
    b = 0;
    while ((1 << b) < sz) b++;
    tot = 4096 * sz;
    if (a + n > tot) return {1'b1, 24'h0};
    return {1'b0, 24'(((a / sz) << b) | (a % sz))};
  endfunction

  // Monitor: pops expected results as done appears
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
      end else begin
        sb_t it;
        it = sbq.pop_front();
        check({err, addr_hi, addr_mid, addr_lo} == it.exp, it.req,
              {7'd0, err, addr_hi, addr_mid, addr_lo}, {7'd0, it.exp});
      end
    end
  end

  task automatic run_conv(input int sel, input bit p2, input int a, input int n,
                          input bit poke, input string req);
    sb_t it;
    it.exp = model(sel, p2, a, n);
    it.req = req;
    sbq.push_back(it);
    @(negedge clk);
    size_sel = 2'(sel); pow2_flag = p2; lin_addr = 24'(a); xfer_len = 24'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", {31'd0, busy}, 32'd1);
    for (int k = 1; k <= 23; k++) begin
      @(negedge clk);
      if (poke && k == 4) begin
        start = 1'b1; lin_addr = 24'(a) ^ 24'h05A5A5; size_sel = 2'd0; pow2_flag = 1'b0;
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done early", {31'd0, done}, 32'd0);
    @(negedge clk);
    check(done == 1'b1, "R8 done at latency", {31'd0, done}, 32'd1);
    @(negedge clk);
    check(busy == 1'b0, "R8 idle after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [24:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({busy, done, err, addr_hi, addr_mid, addr_lo} == 27'd0, "R1 reset state",
          {5'd0, busy, done, err, addr_hi, addr_mid, addr_lo}, 32'd0);

    run_conv(0, 1'b1, 24'h012345, 16, 1'b0, "R5 pass-through 256");
    run_conv(0, 1'b0, 1000, 4, 1'b0, "R3 264-byte page, 9-bit offset");
    run_conv(1, 1'b0, 1048576, 4, 1'b0, "R2 528-byte page");
    run_conv(2, 1'b0, 4325375, 1, 1'b0, "R4 last byte of 1056-byte device");
    run_conv(2, 1'b0, 4325375, 2, 1'b0, "R7 range overflow");
    run_conv(3, 1'b1, 24'h000100, 1, 1'b0, "R10 unsupported size");
    run_conv(1, 1'b1, 24'h1FFFFF, 1, 1'b0, "R6 byte order 512");
    run_conv(0, 1'b0, 263, 1, 1'b0, "R4 remainder size-1");
    run_conv(0, 1'b0, 264, 1, 1'b0, "R4 exact page multiple");
    run_conv(2, 1'b1, 24'h0ABCDE, 8, 1'b1, "R9 start ignored while busy");

    held = {err, addr_hi, addr_mid, addr_lo};
    repeat (6) @(negedge clk);
    // R9 outputs hold between results
    check({err, addr_hi, addr_mid, addr_lo} == held, "R9 hold",
          {7'd0, err, addr_hi, addr_mid, addr_lo}, {7'd0, held});
    check(sbq.size() == 0, "R8 all results seen", sbq.size(), 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule